// File: doc/BRIEF.md
# Parity-Protected Posted Write Controller

This block sits between a 32-bit bus master and a memory that keeps one parity bit per data byte. The master sees a short synchronous termination on every write. The controller then finishes the memory work on its own from a one-entry posting buffer. When all four byte lanes of a word-aligned word are written, the data and four fresh parity bits go to memory in a single access. Any narrower write first fetches the stored word and its parity. It then writes only the enabled data lanes, and writes back all four parity bits. Those bits combine fresh parity for the written lanes with the fetched parity for the lanes left alone.

Reads are whole-word reads. A read returns the stored data and a flag that reports a parity mismatch. A read is taken only after any posted write has reached memory, so a read always sees every earlier write. The memory side is a request/grant port: writes complete on grant, and reads return later with a valid strobe.

Top module: `pp_wctl`

## Requirements
- R1: A write whose address offset is 0 with all four byte enables set is sent to memory as a single write access, with no memory read before it.
- R2: Parity is odd per byte: parity bit i is set when data bits [8i+7:8i] hold an even number of ones. Every written lane carries its freshly computed parity bit. The data write mask `mem_dmask` bit i selects lane i.
- R3: Any other accepted write issues one memory read of the addressed word first, then a write in which only the enabled lanes of data change. The stored bytes of the other lanes keep their values.
- R4: In a partial write, the parity bits of unwritten lanes are copied unchanged from the parity just read, even if that stored parity is wrong. All four parity bits are written.
- R5: `m_ack` for a write is raised in the same cycle the request is taken into the posting buffer, before the memory write has been granted.
- R6: While the posting buffer holds a write, no new request is acknowledged.
- R7: A read request that arrives while a write is pending is held off until that write has reached memory. The read then returns data that includes the write.
- R8: Written lanes are the byte enables shifted left by address bits [1:0], and data is given in lane position. A write that reaches beyond lane 3, or that has no byte enables, gets a one-cycle `m_err` instead of `m_ack` and causes no memory access.
- R9: A read acknowledge carries the stored word on `m_rdata`. It raises `m_perr` when any stored parity bit differs from the odd parity of its data byte.
- R10: While `mem_req` is high and `mem_gnt` is low, the request, direction, address, data and mask stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 1 | Master request, held until `m_ack` or `m_err` |
| m_we | input | 1 | 1 = write, 0 = read |
| m_addr | input | AW | Byte address |
| m_be | input | LANES | Byte enables, before shifting by the address offset |
| m_wdata | input | 8*LANES | Write data in lane position |
| m_ack | output | 1 | Synchronous termination |
| m_err | output | 1 | Write rejected (crosses word or empty) |
| m_rdata | output | 8*LANES | Read data, valid with a read `m_ack` |
| m_perr | output | 1 | Parity mismatch on the read being acknowledged |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW-2 | Word address |
| mem_wdata | output | 8*LANES | Memory write data |
| mem_wpar | output | LANES | Memory write parity, all lanes always written |
| mem_dmask | output | LANES | Data lanes to write |
| mem_gnt | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8*LANES | Read data |
| mem_rpar | input | LANES | Read parity bits |

## Verification
The hardest situation to reach is a read that arrives while a partial write is still waiting for its parity fetch. The stimulus sets a read latency of three cycles and issues a two-lane write. It then presents a read of the same word on the very next cycle and expects the written bytes in the returned data. The parity merge is exposed by pre-corrupting the stored parity of one untouched lane. After a write to a different lane, the stored bad bit must still be there, and a read of that word must flag it.

// File: rtl/pp_wctl.sv
module pp_wctl #(
  parameter int AW    = 16,
  parameter int LANES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         m_req,
  input  logic                         m_we,
  input  logic [AW-1:0]                m_addr,
  input  logic [LANES-1:0]             m_be,
  input  logic [8*LANES-1:0]           m_wdata,
  output logic                         m_ack,
  output logic                         m_err,
  output logic [8*LANES-1:0]           m_rdata,
  output logic                         m_perr,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [AW-$clog2(LANES)-1:0]  mem_addr,
  output logic [8*LANES-1:0]           mem_wdata,
  output logic [LANES-1:0]             mem_wpar,
  output logic [LANES-1:0]             mem_dmask,
  input  logic                         mem_gnt,
  input  logic                         mem_rvalid,
  input  logic [8*LANES-1:0]           mem_rdata,
  input  logic [LANES-1:0]             mem_rpar
);
  localparam int OB = $clog2(LANES);
  localparam int WA = AW - OB;
  localparam int DW = 8 * LANES;

  typedef enum logic [2:0] {S_IDLE, S_WR, S_PRD, S_PWT, S_RD, S_RWT} st_t;

  st_t              st;
  logic [WA-1:0]    b_addr;
  logic [DW-1:0]    b_data;
  logic [LANES-1:0] b_lane;
  logic [LANES-1:0] b_par;

  function automatic logic [LANES-1:0] odd_par(input logic [DW-1:0] d);
    logic [LANES-1:0] p;
    for (int i = 0; i < LANES; i++) p[i] = ~^d[8*i +: 8];
    return p;
  endfunction

  logic [2*LANES-1:0] shl;
  logic [LANES-1:0]   lanes;
  logic               bad, idle, wr_take, rd_take, rd_done;

  assign shl     = {{LANES{1'b0}}, m_be} << m_addr[OB-1:0];
  assign lanes   = shl[LANES-1:0];
  assign bad     = (|shl[2*LANES-1:LANES]) || (m_be == '0);
  assign idle    = (st == S_IDLE);
  assign wr_take = idle && m_req && m_we && !bad;
  assign rd_take = idle && m_req && !m_we;
  assign rd_done = (st == S_RWT) && mem_rvalid;

  assign m_err   = idle && m_req && m_we && bad;
  assign m_ack   = wr_take || rd_done;
  assign m_rdata = mem_rdata;
  assign m_perr  = rd_done && (|(mem_rpar ^ odd_par(mem_rdata)));

  assign mem_req   = (st == S_WR) || (st == S_PRD) || (st == S_RD);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = b_addr;
  assign mem_wdata = b_data;
  assign mem_wpar  = b_par;
  assign mem_dmask = b_lane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      b_addr <= '0;
      b_data <= '0;
      b_lane <= '0;
      b_par  <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (wr_take) begin
            b_addr <= m_addr[AW-1:OB];
            b_data <= m_wdata;
            b_lane <= lanes;
            b_par  <= odd_par(m_wdata);
            st     <= (&lanes) ? S_WR : S_PRD;
          end else if (rd_take) begin
            b_addr <= m_addr[AW-1:OB];
            st     <= S_RD;
          end
        end
        S_WR:  if (mem_gnt) st <= S_IDLE;
        S_PRD: if (mem_gnt) st <= S_PWT;
        S_PWT: if (mem_rvalid) begin
          b_par <= (b_par & b_lane) | (mem_rpar & ~b_lane);
          st    <= S_WR;
        end
        S_RD:  if (mem_gnt) st <= S_RWT;
        S_RWT: if (mem_rvalid) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pp_wctl_chk.sv
module pp_wctl_chk #(
  parameter int AW    = 16,
  parameter int LANES = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         m_req,
  input logic                         m_we,
  input logic [$clog2(LANES)-1:0]     m_off,
  input logic [LANES-1:0]             m_be,
  input logic                         m_ack,
  input logic                         m_err,
  input logic                         mem_req,
  input logic                         mem_gnt,
  input logic                         mem_we,
  input logic [AW-$clog2(LANES)-1:0]  mem_addr,
  input logic [8*LANES-1:0]           mem_wdata,
  input logic [LANES-1:0]             mem_wpar,
  input logic [LANES-1:0]             mem_dmask
);
  function automatic logic [LANES-1:0] exp_par(input logic [8*LANES-1:0] d);
    logic [LANES-1:0] p;
    for (int i = 0; i < LANES; i++) begin
      p[i] = 1'b1;
      for (int b = 0; b < 8; b++) p[i] = p[i] ^ d[8*i+b];
    end
    return p;
  endfunction

  logic full_wr;
  assign full_wr = m_req && m_we && (m_off == '0) && (&m_be);

  a_r1_full_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ack && full_wr) |=> (mem_req && mem_we));

  a_r3_partial_reads_first: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ack && m_req && m_we && !full_wr) |=> (mem_req && !mem_we));

  a_r2_written_lanes_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (((mem_wpar ^ exp_par(mem_wdata)) & mem_dmask) == '0));

  a_r6_no_ack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !(m_ack && m_we));

  a_r8_err_excludes_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_ack && m_err));

  a_r10_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                               && $stable(mem_wdata) && $stable(mem_dmask)));
endmodule

bind pp_wctl pp_wctl_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we),
  .m_off(m_addr[$clog2(LANES)-1:0]), .m_be(m_be), .m_ack(m_ack), .m_err(m_err),
  .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_wpar(mem_wpar), .mem_dmask(mem_dmask)
);

// File: tb/pp_wctl_bench.sv
module pp_wctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_req = 1'b0, m_we = 1'b0;
  logic [15:0] m_addr = '0;
  logic [3:0]  m_be = '0;
  logic [31:0] m_wdata = '0;
  logic        m_ack, m_err, m_perr;
  logic [31:0] m_rdata;
  logic        mem_req, mem_we;
  logic [13:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0]  mem_wpar, mem_dmask, mem_rpar;
  logic        mem_gnt, mem_rvalid;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pp_wctl u_pp_wctl (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_be(m_be), .m_wdata(m_wdata), .m_ack(m_ack), .m_err(m_err),
    .m_rdata(m_rdata), .m_perr(m_perr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wpar(mem_wpar),
    .mem_dmask(mem_dmask), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_rpar(mem_rpar)
  );

  // memory model
  logic [31:0] mdat [0:63];
  logic [3:0]  mpar [0:63];
  bit          gnt_en = 1;
  int          rlat = 1, rcd = 0, rd_cnt = 0, wr_cnt = 0;
  logic [5:0]  raddr = '0;

  assign mem_gnt    = gnt_en;
  assign mem_rvalid = (rcd == 1);
  assign mem_rdata  = mdat[raddr];
  assign mem_rpar   = mpar[raddr];

  always @(posedge clk) begin
    if (mem_req && mem_gnt && mem_we) begin
      for (int i = 0; i < 4; i++)
        if (mem_dmask[i]) mdat[mem_addr[5:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
      mpar[mem_addr[5:0]] <= mem_wpar;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_req && mem_gnt && !mem_we) begin
      raddr  <= mem_addr[5:0];
      rcd    <= rlat;
      rd_cnt <= rd_cnt + 1;
    end else if (rcd > 0) rcd <= rcd - 1;
  end

  function automatic logic [3:0] opar(input logic [31:0] d);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) begin
      p[i] = 1'b1;
      for (int b = 0; b < 8; b++) p[i] = p[i] ^ d[8*i+b];
    end
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d,
                    output bit err);
    @(negedge clk);
    m_req = 1; m_we = 1; m_addr = a; m_be = be; m_wdata = d;
    err = 0;
    forever begin
      #1;
      if (m_ack || m_err) begin
        err = m_err;
        @(negedge clk);
        m_req = 0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d, output bit pe);
    @(negedge clk);
    m_req = 1; m_we = 0; m_addr = a; m_be = 4'hF;
    forever begin
      #1;
      if (m_ack) begin
        d = m_rdata; pe = m_perr;
        @(negedge clk);
        m_req = 0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic drain();
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk(!m_ack && !m_err && !mem_req, "R5 reset idle", {29'd0, m_ack, m_err, mem_req}, 0);
  endtask

  task automatic t_full();
    bit e; int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    wr(16'h0010, 4'hF, 32'hA501FF3C, e);
    chk(wr_cnt == w0, "R5 ack before memory write", wr_cnt, w0);
    drain();
    chk(rd_cnt == r0, "R1 no read on full write", rd_cnt, r0);
    chk(mdat[4] == 32'hA501FF3C, "R1 full data", mdat[4], 32'hA501FF3C);
    chk(mpar[4] == opar(32'hA501FF3C), "R2 odd parity", mpar[4], opar(32'hA501FF3C));
  endtask

  task automatic t_partial();
    bit e; int r0;
    mdat[5] = 32'h11223344; mpar[5] = opar(32'h11223344);
    r0 = rd_cnt; rlat = 2;
    wr(16'h0015, 4'h1, 32'h0000AB00, e);
    drain();
    chk(rd_cnt == r0 + 1, "R3 one parity read", rd_cnt, r0 + 1);
    chk(mdat[5] == 32'h1122AB44, "R3 untouched lanes kept", mdat[5], 32'h1122AB44);
    chk(mpar[5] == opar(32'h1122AB44), "R4 merged parity", mpar[5], opar(32'h1122AB44));
  endtask

  task automatic t_merge();
    bit e, pe; logic [31:0] d; logic [3:0] exp;
    mdat[6] = 32'h55667788; mpar[6] = opar(32'h55667788) ^ 4'b1000;
    wr(16'h0018, 4'h1, 32'h000000EE, e);
    drain();
    exp = opar(32'h556677EE) ^ 4'b1000;
    chk(mpar[6] == exp, "R4 stale bit of untouched lane kept", mpar[6], exp);
    rd(16'h0018, d, pe);
    chk(d == 32'h556677EE, "R9 read data", d, 32'h556677EE);
    chk(pe == 1'b1, "R9 parity error flagged", pe, 1);
  endtask

  task automatic t_stall();
    bit e, seen;
    gnt_en = 0;
    wr(16'h001C, 4'hF, 32'h01020304, e);
    m_req = 1; m_we = 1; m_addr = 16'h0020; m_be = 4'hF; m_wdata = 32'hDEADBEEF;
    seen = 0;
    repeat (5) begin #1; if (m_ack) seen = 1; @(negedge clk); end
    chk(!seen, "R6 no ack while buffer full", seen, 0);
    gnt_en = 1;
    seen = 0;
    repeat (6) begin #1; if (m_ack) seen = 1; @(negedge clk); if (seen) m_req = 0; end
    m_req = 0;
    chk(seen, "R6 ack after buffer frees", seen, 1);
    drain();
    chk(mdat[8] == 32'hDEADBEEF, "R6 second write done", mdat[8], 32'hDEADBEEF);
  endtask

  task automatic t_order();
    bit e, pe; logic [31:0] d;
    rlat = 3;
    mdat[9] = 32'h00000000; mpar[9] = opar(32'h0);
    wr(16'h0024, 4'h3, 32'h0000BEEF, e);
    rd(16'h0024, d, pe);
    chk(d == 32'h0000BEEF, "R7 read sees posted write", d, 32'h0000BEEF);
    chk(pe == 1'b0, "R9 clean read no error", pe, 0);
    rlat = 1;
  endtask

  task automatic t_err();
    bit e; int r0, w0;
    mdat[10] = 32'hCCCCCCCC;
    r0 = rd_cnt; w0 = wr_cnt;
    wr(16'h0029, 4'hF, 32'h12345678, e);
    chk(e, "R8 crossing write rejected", e, 1);
    wr(16'h0028, 4'h0, 32'h12345678, e);
    chk(e, "R8 empty enables rejected", e, 1);
    drain();
    chk(rd_cnt == r0 && wr_cnt == w0, "R8 no memory access", rd_cnt + wr_cnt, r0 + w0);
    chk(mdat[10] == 32'hCCCCCCCC, "R8 word untouched", mdat[10], 32'hCCCCCCCC);
  endtask

  task automatic t_offset();
    bit e;
    mdat[11] = 32'h12345678; mpar[11] = opar(32'h12345678);
    wr(16'h002E, 4'h3, 32'hCAFE0000, e);
    drain();
    chk(!e, "R8 in-word offset accepted", e, 0);
    chk(mdat[11] == 32'hCAFE5678, "R8 lanes shifted by offset", mdat[11], 32'hCAFE5678);
    chk(mpar[11] == opar(32'hCAFE5678), "R2 parity after offset write", mpar[11], opar(32'hCAFE5678));
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin mdat[i] = '0; mpar[i] = 4'hF; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_full();
    t_partial();
    t_merge();
    t_stall();
    t_order();
    t_err();
    t_offset();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule